// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Detect

This block compares the timing of two slow square waves, a divided oscillator signal and a divided reference, using a fast sampling clock. Each input is resynchronised and reduced to a one-cycle rising-edge event. An edge on the reference input arms an active-low pump-up output. An edge on the divided input arms an active-low pump-down output. The output armed first stays low until the other edge arrives. The next cycle then releases both outputs. As a result, the width of a pulse in clock cycles follows the phase or frequency error.

An activity signal is formed as the NAND of the two pump outputs. It feeds a digital lock filter. The filter measures how long each run of activity lasts. It declares lock after a parameterised number of back-to-back narrow comparisons and drops lock on the first wide one. A power-down input forces both pump outputs inactive and clears the filter.

Top module: `phase_freq_det`

## Requirements
- R1: While reset is active, and after it is released with no input edge, both pump outputs are 1, activity is 0 and lock is 0.
- R2: When the reference rising edge precedes the divided rising edge by k sampling cycles, pump_up_no is low for k+1 consecutive cycles and pump_dn_no is low for exactly 1 cycle, the last one.
- R3: When the divided rising edge precedes the reference rising edge by k cycles, pump_dn_no is low for k+1 cycles and pump_up_no is low for exactly 1 cycle.
- R4: Rising edges on both inputs in the same cycle drive both pump outputs low for exactly one cycle.
- R5: Only rising edges count. A falling input, or an input held high, produces no pump pulse.
- R6: activity_o is 1 exactly when at least one pump output is 0.
- R7: lock_o rises one cycle after a comparison completes (the cycle both pumps are low) when the last LOCK_COUNT (default 16) comparisons in a row each had activity lasting at most MAX_WIDTH (default 2) cycles.
- R8: When activity has lasted MAX_WIDTH+1 cycles, lock_o is 0 from the next cycle on and the count of good comparisons restarts from zero.
- R9: While pwrdn_i is 1, both pump outputs are 1 and activity is 0 in the same cycle. lock_o is 0 from the next cycle, and the good-comparison count is cleared.
- R10: A rising input edge first shows at the pump output SYNC_STAGES+1 (default 3) clock edges after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 1 | Divided oscillator signal (asynchronous) |
| ref_i | input | 1 | Divided reference signal (asynchronous) |
| pwrdn_i | input | 1 | Power-down: outputs held inactive, lock cleared |
| pump_up_no | output | 1 | Raise-frequency pulse, active low |
| pump_dn_no | output | 1 | Lower-frequency pulse, active low |
| activity_o | output | 1 | NAND of the two pump outputs, unfiltered |
| lock_o | output | 1 | Filtered lock indication |

## Verification
A flag that is stuck or not cleared shows as a pump pulse that is one or more cycles too long or too short. It is visible within the comparison that exposes it. A wrong width or good-count value in the lock filter shows as lock_o rising one comparison early or late. It can also show as lock_o not falling on the cycle after the third active cycle. A synchroniser depth error shifts the first low pump sample away from three edges after the input changes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic [0:0] {CH_REF = 1'b0, CH_DIV = 1'b1} ch_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q[s] <= 1'b0;
      else if (s == 0) sh_q[s] <= sig_i;
      else             sh_q[s] <= sh_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sh_q[STAGES-1];
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_i,
  input  logic rise_ref_i,
  input  logic rise_div_i,
  output logic up_o,
  output logic dn_o,
  output logic done_o
);
  logic up_q, dn_q, both;

  assign both = up_q & dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (pwrdn_i) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      // overlap releases both flags; a fresh edge in that cycle re-arms
      up_q <= (both ? 1'b0 : up_q) | rise_ref_i;
      dn_q <= (both ? 1'b0 : dn_q) | rise_div_i;
    end
  end

  assign up_o   = up_q;
  assign dn_o   = dn_q;
  assign done_o = both;
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int unsigned MAX_WIDTH  = 2,
  parameter int unsigned LOCK_COUNT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwrdn_i,
  input  logic act_i,
  input  logic done_i,
  output logic lock_o
);
  localparam int unsigned RW = $clog2(MAX_WIDTH + 1) + 1;
  localparam int unsigned CW = $clog2(LOCK_COUNT + 1) + 1;

  logic [RW-1:0] run_q;
  logic [CW-1:0] good_q;
  logic          lock_q;
  logic          wide;

  assign wide = act_i & (run_q >= RW'(MAX_WIDTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (pwrdn_i) begin
      run_q  <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      if (!act_i)                        run_q <= '0;
      else if (run_q < RW'(MAX_WIDTH))   run_q <= run_q + 1'b1;
      if (wide) begin
        good_q <= '0;
        lock_q <= 1'b0;
      end else if (done_i) begin
        if (good_q >= CW'(LOCK_COUNT - 1)) lock_q <= 1'b1;
        else                               good_q <= good_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_WIDTH   = 2,
  parameter int unsigned LOCK_COUNT  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_i,
  input  logic ref_i,
  input  logic pwrdn_i,
  output logic pump_up_no,
  output logic pump_dn_no,
  output logic activity_o,
  output logic lock_o
);
  import pfd_pkg::*;

  logic [NUM_CH-1:0] raw, rise;
  logic up, dn, done;

  assign raw[CH_REF] = ref_i;
  assign raw[CH_DIV] = div_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (raw[c]),
      .rise_o(rise[c])
    );
  end

  pfd_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwrdn_i   (pwrdn_i),
    .rise_ref_i(rise[CH_REF]),
    .rise_div_i(rise[CH_DIV]),
    .up_o      (up),
    .dn_o      (dn),
    .done_o    (done)
  );

  assign pump_up_no = ~(up & ~pwrdn_i);
  assign pump_dn_no = ~(dn & ~pwrdn_i);
  assign activity_o = ~(pump_up_no & pump_dn_no);

  pfd_lock #(.MAX_WIDTH(MAX_WIDTH), .LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwrdn_i(pwrdn_i),
    .act_i  (activity_o),
    .done_i (done & ~pwrdn_i),
    .lock_o (lock_o)
  );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pwrdn_i,
  input logic pump_up_no,
  input logic pump_dn_no,
  input logic activity_o,
  input logic lock_o
);
  p_act_nand_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_o == !(pump_up_no && pump_dn_no));

  p_pwrdn_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |-> (pump_up_no && pump_dn_no));

  p_pwrdn_unlock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_i |=> !lock_o);

  p_lock_at_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(!pump_up_no && !pump_dn_no));

  p_wide_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (activity_o && $past(activity_o) && $past(activity_o, 2) && !pwrdn_i) |=> !lock_o);
endmodule

bind phase_freq_det pfd_checker u_pfd_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwrdn_i   (pwrdn_i),
  .pump_up_no(pump_up_no),
  .pump_dn_no(pump_dn_no),
  .activity_o(activity_o),
  .lock_o    (lock_o)
);

// File: tb/phase_freq_det_bench.sv
module phase_freq_det_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;
  localparam int WIN  = 24;
  localparam int HOLD = 12;
  localparam int NV   = 6;
  // {div edge cycle, ref edge cycle, expected up width, expected down width}
  localparam int VEC [NV][4] = '{
    '{0, 0, 1, 1}, '{2, 0, 3, 1}, '{0, 3, 1, 4},
    '{1, 0, 2, 1}, '{0, 1, 1, 2}, '{5, 0, 6, 1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic div_s = 1'b0, ref_s = 1'b0, pwrdn = 1'b0;
  logic pu_n, pd_n, act, lock;
  int checks = 0, fails = 0;
  int cnt_u, cnt_d, bad_act, first_u, first_d, lock_after;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_freq_det u_phase_freq_det (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_s), .ref_i(ref_s), .pwrdn_i(pwrdn),
    .pump_up_no(pu_n), .pump_dn_no(pd_n), .activity_o(act), .lock_o(lock));

  task automatic chk(input bit ok, input string req, input int actual, input int expect_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expect_v);
    end
  endtask

  task automatic run_cmp(input int dd, input int dr);
    logic prev_act;
    cnt_u = 0; cnt_d = 0; bad_act = 0; first_u = -1; first_d = -1; lock_after = -1;
    prev_act = 1'b0;
    for (int t = 0; t < WIN; t++) begin
      @(negedge clk);
      if (!pu_n) begin cnt_u++; if (first_u < 0) first_u = t; end
      if (!pd_n) begin cnt_d++; if (first_d < 0) first_d = t; end
      if (act !== !(pu_n && pd_n)) bad_act++;
      if (prev_act && !act && lock_after < 0) lock_after = int'(lock);
      prev_act = act;
      div_s = (t >= dd) && (t < HOLD);
      ref_s = (t >= dr) && (t < HOLD);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(pu_n && pd_n && !act && !lock, "R1 in reset", {pu_n, pd_n, act, lock}, 4'b1100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pu_n && pd_n && !act && !lock, "R1 after reset", {pu_n, pd_n, act, lock}, 4'b1100);

    for (int v = 0; v < NV; v++) begin
      run_cmp(VEC[v][0], VEC[v][1]);
      chk(cnt_u == VEC[v][2], $sformatf("R2 up width vec%0d", v), cnt_u, VEC[v][2]);
      chk(cnt_d == VEC[v][3], $sformatf("R3 dn width vec%0d", v), cnt_d, VEC[v][3]);
      chk(bad_act == 0, $sformatf("R6 activity vec%0d", v), bad_act, 0);
    end
    // R4 coincident edges
    run_cmp(0, 0);
    chk(cnt_u == 1 && cnt_d == 1 && first_u == first_d, "R4 coincident", cnt_u + cnt_d, 2);
    // R10 latency from ref edge
    run_cmp(2, 0);
    chk(first_u == LAT, "R10 latency", first_u, LAT);

    // R5: falling and held-high inputs
    @(negedge clk); div_s = 1'b1; ref_s = 1'b1;
    repeat (10) @(negedge clk);
    cnt_u = 0; cnt_d = 0;
    ref_s = 1'b0;
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      if (!pu_n) cnt_u++;
      if (!pd_n) cnt_d++;
    end
    div_s = 1'b0;
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      if (!pu_n) cnt_u++;
      if (!pd_n) cnt_d++;
    end
    chk(cnt_u == 0 && cnt_d == 0, "R5 no pulse on fall", cnt_u + cnt_d, 0);

    // R7: clear count via power-down, then 16 narrow comparisons
    @(negedge clk); pwrdn = 1'b1;
    @(negedge clk); pwrdn = 1'b0;
    for (int i = 0; i < 15; i++) run_cmp(0, 0);
    chk(!lock, "R7 no lock after 15", lock, 0);
    run_cmp(0, 0);
    chk(lock, "R7 lock after 16", lock, 1);
    run_cmp(1, 0);
    chk(lock && lock_after == 1, "R7 width 2 keeps lock", lock, 1);

    // R8: width 3 drops lock at once and restarts count
    run_cmp(2, 0);
    chk(lock_after == 0, "R8 drop at pulse end", lock_after, 0);
    chk(!lock, "R8 stays unlocked", lock, 0);
    for (int i = 0; i < 15; i++) run_cmp(0, 1);
    chk(!lock, "R8 count restarted", lock, 0);
    run_cmp(0, 0);
    chk(lock, "R8 relock after 16", lock, 1);

    // R9: power-down
    @(negedge clk); pwrdn = 1'b1;
    @(negedge clk);
    chk(!lock, "R9 lock cleared", lock, 0);
    run_cmp(3, 0);
    chk(cnt_u == 0 && cnt_d == 0, "R9 pumps held high", cnt_u + cnt_d, 0);
    chk(bad_act == 0 && !act, "R9 activity low", act, 0);
    pwrdn = 1'b0;
    for (int i = 0; i < 15; i++) run_cmp(0, 0);
    chk(!lock, "R9 count cleared", lock, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule